// File: doc/BRIEF.md
# Round-Robin Result Collector

This block drains finished result packets from a set of processing clusters into one output FIFO. Each cluster owns a small result buffer with a second read port that the collector can address. When a cluster has a complete result in that buffer, it raises its ready line and holds it. The collector picks one ready cluster through a rotating-priority arbiter, reads that cluster's buffer word by word and offers each word to the FIFO over a request/acknowledge handshake. After the last word is accepted, it pulses a one-cycle release to that cluster.

Packets describe their own length. The word at buffer address 0 is a header whose low `ADDR_W` bits give the number of payload words that follow it. The header is forwarded unchanged, followed by payload addresses 1 to L. A busy FIFO stalls the collector without losing or repeating a word.

The control is a five-state machine:

- **IDLE**: wait for any ready cluster. The transition *grant* latches the chosen cluster and clears the word counter.
- **FETCH**: issue the header read. The transition *issue* goes to LATCH.
- **LATCH**: capture the buffer word. For the header, the payload count is loaded. The transition *present* goes to SEND.
- **SEND**: hold the request until it is acknowledged. The transition *next word* issues the following read and returns to LATCH. The transition *last word* goes to RELEASE.
- **RELEASE**: pulse the release to the served cluster and advance the priority pointer. The transition *rearm* returns to IDLE.

Top module: `rr_result_collector`

## Requirements
- R1: After reset, `fifo_req_o`, `buf_rd_o` and every bit of `done_o` are 0, and the priority pointer starts at cluster 0.
- R2: Among the clusters whose `ready_i` bit is 1, the one granted is the first found when searching upward from the pointer and wrapping after cluster N-1. After a cluster is released, the pointer becomes the index one above that cluster, wrapping to 0 after N-1.
- R3: A packet is the header word at buffer address 0 followed by the L words at addresses 1..L, where L is header bits [ADDR_W-1:0]. Exactly L+1 words reach the FIFO, in address order, and the header's upper bits are forwarded but never used as a length.
- R4: A word is handed over on a clock edge where `fifo_req_o` and `fifo_ack_i` are both 1. While the request is pending without acknowledge, the request stays high, `fifo_data_o` is unchanged and no buffer read is issued.
- R5: After the last word of a packet is accepted, `done_o` pulses high for exactly one cycle, on the bit of the served cluster only. At most one bit of `done_o` is ever high.
- R6: A buffer read (`buf_rd_o` = 1) only addresses a cluster (`buf_sel_o`) whose ready bit is 1.
- R7: With no ready cluster, the block stays in IDLE: no request, no read and no release.
- R8: Both length extremes are served. L = 0 sends only the header. L = DEPTH-1 sends every word of the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready_i | input | N_CL | Per-cluster result-ready, held until released |
| done_o | output | N_CL | One-cycle release pulse to the served cluster |
| buf_sel_o | output | IDX_W | Cluster whose buffer is addressed |
| buf_addr_o | output | ADDR_W | Word address within that buffer |
| buf_rd_o | output | 1 | Buffer read strobe; data returns next cycle |
| buf_rdata_i | input | N_CL*DATA_W | Read ports of all cluster buffers, cluster 0 in the low slice |
| fifo_req_o | output | 1 | Output word valid / request |
| fifo_data_o | output | DATA_W | Output word |
| fifo_ack_i | input | 1 | FIFO accepts the word on this edge |

## Verification
The assertions make several assumptions about the inputs:

- A cluster keeps its ready bit high from the moment it is raised until the cycle after its release pulse.
- A buffer returns the addressed word one cycle after a read and holds it until the next read.
- The FIFO acknowledge is free to toggle in any cycle.

The bench's cluster models meet these assumptions by construction. Ready bits are set only through a registered mask that is cleared by `done_o`. Buffers are filled only between batches, when every cluster has been released. The acknowledge is drawn each cycle with a chosen probability, from always-high down to rare, so that long stalls occur.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LATCH,
        ST_SEND,
        ST_RELEASE
    } coll_state_e;

endpackage

// File: rtl/rrc_rr_pick.sv
module rrc_rr_pick #(
    parameter int N_CL  = 16,
    parameter int IDX_W = 4
) (
    input  logic [N_CL-1:0]  req_i,
    input  logic [IDX_W-1:0] ptr_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam int SUM_W = IDX_W + 1;

    logic [IDX_W-1:0] cand [N_CL];

    // Candidate k is (ptr + k) wrapped into 0..N_CL-1.
    for (genvar k = 0; k < N_CL; k++) begin : g_cand
        logic [SUM_W-1:0] sum;
        assign sum = {1'b0, ptr_i} + SUM_W'(k);
        assign cand[k] = (sum >= SUM_W'(N_CL)) ? IDX_W'(sum - SUM_W'(N_CL))
                                               : IDX_W'(sum);
    end

    // Scan from the farthest candidate down, so the nearest one wins.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int k = N_CL - 1; k >= 0; k--) begin
            if (req_i[cand[k]]) begin
                any_o = 1'b1;
                idx_o = cand[k];
            end
        end
    end

endmodule

// File: rtl/rrc_rdata_mux.sv
module rrc_rdata_mux #(
    parameter int N_CL   = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic [N_CL*DATA_W-1:0] flat_i,
    input  logic [IDX_W-1:0]       sel_i,
    output logic [DATA_W-1:0]      word_o
);

    logic [DATA_W-1:0] slice [N_CL];

    for (genvar c = 0; c < N_CL; c++) begin : g_slice
        assign slice[c] = flat_i[c*DATA_W +: DATA_W];
    end

    assign word_o = slice[sel_i];

endmodule

// File: rtl/rrc_word_cnt.sv
module rrc_word_cnt #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              addr_inc_i,
    input  logic              len_load_i,
    input  logic [ADDR_W-1:0] len_i,
    input  logic              rem_dec_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else begin
            if (clr_i) begin
                addr_q <= '0;
            end else if (addr_inc_i) begin
                addr_q <= addr_q + 1'b1;
            end

            if (len_load_i) begin
                rem_q <= len_i;
            end else if (rem_dec_i) begin
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    assign addr_o = addr_q;
    assign last_o = (rem_q == '0);

    // R3: the controller never steps past the announced payload count.
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rem_dec_i |-> !last_o);

endmodule

// File: rtl/rr_result_collector.sv
module rr_result_collector #(
    parameter int N_CL   = 16,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 256,
    parameter int IDX_W  = (N_CL > 1) ? $clog2(N_CL) : 1,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CL-1:0]        ready_i,
    output logic [N_CL-1:0]        done_o,
    output logic [IDX_W-1:0]       buf_sel_o,
    output logic [ADDR_W-1:0]      buf_addr_o,
    output logic                   buf_rd_o,
    input  logic [N_CL*DATA_W-1:0] buf_rdata_i,
    output logic                   fifo_req_o,
    output logic [DATA_W-1:0]      fifo_data_o,
    input  logic                   fifo_ack_i
);

    import rrc_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CL - 1);

    coll_state_e state_q, state_d;

    logic [IDX_W-1:0]  ptr_q;
    logic [IDX_W-1:0]  gnt_q;
    logic [DATA_W-1:0] word_q;
    logic              hdr_q;

    logic              pick_any;
    logic [IDX_W-1:0]  pick_idx;
    logic [DATA_W-1:0] rd_word;
    logic [ADDR_W-1:0] cnt_addr;
    logic              cnt_last;

    logic take_gnt, cnt_clr, addr_inc, rem_dec, len_load, latch_word, adv_ptr;

    rrc_rr_pick #(
        .N_CL  (N_CL),
        .IDX_W (IDX_W)
    ) u_pick (
        .req_i (ready_i),
        .ptr_i (ptr_q),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    rrc_rdata_mux #(
        .N_CL   (N_CL),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_mux (
        .flat_i (buf_rdata_i),
        .sel_i  (gnt_q),
        .word_o (rd_word)
    );

    rrc_word_cnt #(
        .ADDR_W (ADDR_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (cnt_clr),
        .addr_inc_i (addr_inc),
        .len_load_i (len_load),
        .len_i      (rd_word[ADDR_W-1:0]),
        .rem_dec_i  (rem_dec),
        .addr_o     (cnt_addr),
        .last_o     (cnt_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers steered by the controller
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            gnt_q  <= '0;
            word_q <= '0;
            hdr_q  <= 1'b0;
        end else begin
            if (take_gnt) begin
                gnt_q <= pick_idx;
                hdr_q <= 1'b1;
            end
            if (latch_word) begin
                word_q <= rd_word;
                hdr_q  <= 1'b0;
            end
            if (adv_ptr) begin
                ptr_q <= (gnt_q == LAST_IDX) ? '0 : gnt_q + 1'b1;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d    = state_q;
        buf_rd_o   = 1'b0;
        fifo_req_o = 1'b0;
        done_o     = '0;
        take_gnt   = 1'b0;
        cnt_clr    = 1'b0;
        addr_inc   = 1'b0;
        rem_dec    = 1'b0;
        len_load   = 1'b0;
        latch_word = 1'b0;
        adv_ptr    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pick_any) begin
                    take_gnt = 1'b1;
                    cnt_clr  = 1'b1;
                    state_d  = ST_FETCH;
                end
            end
            ST_FETCH: begin
                buf_rd_o = 1'b1;
                addr_inc = 1'b1;
                state_d  = ST_LATCH;
            end
            ST_LATCH: begin
                latch_word = 1'b1;
                len_load   = hdr_q;
                state_d    = ST_SEND;
            end
            ST_SEND: begin
                fifo_req_o = 1'b1;
                if (fifo_ack_i) begin
                    if (cnt_last) begin
                        state_d = ST_RELEASE;
                    end else begin
                        buf_rd_o = 1'b1;
                        addr_inc = 1'b1;
                        rem_dec  = 1'b1;
                        state_d  = ST_LATCH;
                    end
                end
            end
            ST_RELEASE: begin
                done_o[gnt_q] = 1'b1;
                adv_ptr       = 1'b1;
                state_d       = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign buf_sel_o   = gnt_q;
    assign buf_addr_o  = cnt_addr;
    assign fifo_data_o = word_q;

    // R4: a pending, unacknowledged word is held steady.
    p_hold_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_req_o && !fifo_ack_i) |=> (fifo_req_o && $stable(fifo_data_o)));

    // R4: no buffer read is issued while the FIFO is holding off.
    p_no_read_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_req_o && !fifo_ack_i) |-> !buf_rd_o);

    // R5: at most one cluster is released at a time.
    p_done_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_o));

    // R5: a release follows an accepted word.
    p_done_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o != '0) |-> $past(fifo_req_o && fifo_ack_i));

    // R6: reads only target a cluster that has a result waiting.
    p_read_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_o |-> ready_i[buf_sel_o]);

    // R2: the arbiter's choice is always a ready cluster.
    p_grant_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && pick_any) |-> ready_i[pick_idx]);

endmodule

// File: tb/sim_rr_result_collector.sv
`timescale 1ns/1ps
module sim_rr_result_collector;

    localparam int N  = 16;
    localparam int W  = 32;
    localparam int D  = 256;
    localparam int AW = 8;
    localparam int IW = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    ready = '0;
    logic [N-1:0]    set_mask = '0;
    logic [N-1:0]    done;
    logic [IW-1:0]   sel;
    logic [AW-1:0]   addr;
    logic            rd;
    logic [N*W-1:0]  rdata = '0;
    logic            req;
    logic [W-1:0]    data;
    logic            ack = 1'b0;

    int ack_pct = 100;
    int tests = 0;
    int fails = 0;
    int exp_ptr = 0;
    int batch_no = 0;

    logic [W-1:0] mem [N][D];
    logic [W-1:0] rx [$];
    int           dq [$];
    int onehot_err = 0, stall_err = 0, unready_err = 0, idle_act = 0;
    logic         prev_stall = 1'b0;
    logic [W-1:0] prev_data = '0;

    always #5 clk = ~clk;

    rr_result_collector #(.N_CL(N), .DATA_W(W), .DEPTH(D)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready_i     (ready),
        .done_o      (done),
        .buf_sel_o   (sel),
        .buf_addr_o  (addr),
        .buf_rd_o    (rd),
        .buf_rdata_i (rdata),
        .fifo_req_o  (req),
        .fifo_data_o (data),
        .fifo_ack_i  (ack)
    );

    // Cluster models: ready held until released, synchronous buffer read.
    always @(posedge clk) begin
        if (!rst_n) ready <= '0;
        else        ready <= (ready & ~done) | set_mask;
        if (rd) rdata[sel*W +: W] <= mem[sel][addr];
    end

    task automatic chk(input bit ok, input string rq, input string msg);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", rq, msg);
        end
    endtask

    // Acknowledge driver and port monitor, away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            ack = (int'($urandom % 100) < ack_pct);
            #1;
            if (rst_n) begin
                if ($countones(done) > 1) onehot_err++;
                for (int i = 0; i < N; i++) if (done[i]) dq.push_back(i);
                if (prev_stall && !(req && data == prev_data)) stall_err++;
                if (rd && !ready[sel]) unready_err++;
                if (ready == '0 && set_mask == '0 && (req || rd || done != '0)) idle_act++;
                if (req && ack) rx.push_back(data);
                prev_stall = req && !ack;
                prev_data  = data;
            end
        end
    end

    function automatic void exp_order(input logic [N-1:0] m, input int p, output int q[$]);
        q = {};
        for (int k = 0; k < N; k++) begin
            int j;
            j = (p + k) % N;
            if (m[j]) q.push_back(j);
        end
    endfunction

    task automatic run_batch(input logic [N-1:0] mask, input int maxlen, input int fixed_len,
                             input string tag);
        int order[$];
        logic [W-1:0] ew[$];
        int cnt;
        int nreq;
        bit ok;
        int bad_at;
        batch_no++;
        exp_order(mask, exp_ptr, order);
        nreq = order.size();
        for (int c = 0; c < N; c++) begin
            if (mask[c]) begin
                int len;
                logic [W-1:0] hdr;
                len = (fixed_len >= 0) ? fixed_len : int'($urandom % (maxlen + 1));
                hdr = $urandom;
                hdr[AW-1:0] = AW'(len);
                mem[c][0] = hdr;
                for (int k = 1; k <= len; k++)
                    mem[c][k] = {8'(c), 8'(batch_no), 16'(k)};
            end
        end
        foreach (order[i]) begin
            int len;
            len = int'(mem[order[i]][0][AW-1:0]);
            for (int k = 0; k <= len; k++) ew.push_back(mem[order[i]][k]);
        end
        stall_err = 0;
        @(negedge clk);
        rx.delete();
        dq.delete();
        set_mask = mask;
        @(negedge clk);
        set_mask = '0;
        cnt = 0;
        while (dq.size() < nreq && cnt < 60000) begin
            @(negedge clk);
            cnt++;
        end
        repeat (6) @(negedge clk);
        // R2 / R5: release order and count
        ok = (dq.size() == nreq);
        bad_at = -1;
        if (ok) foreach (order[i]) if (dq[i] != order[i] && bad_at < 0) bad_at = i;
        ok = ok && (bad_at < 0);
        chk(ok, "R2", $sformatf("%s order: got %0d releases first diff at %0d (act %0d exp %0d), exp %0d releases",
            tag, dq.size(), bad_at, (bad_at >= 0) ? dq[bad_at] : -1,
            (bad_at >= 0) ? order[bad_at] : -1, nreq));
        // R3: word stream content
        ok = (rx.size() == ew.size());
        bad_at = -1;
        if (ok) foreach (ew[i]) if (rx[i] != ew[i] && bad_at < 0) bad_at = i;
        ok = ok && (bad_at < 0);
        chk(ok, "R3", $sformatf("%s words: act count %0d exp %0d, first diff idx %0d act %h exp %h",
            tag, rx.size(), ew.size(), bad_at,
            (bad_at >= 0) ? rx[bad_at] : '0, (bad_at >= 0) ? ew[bad_at] : '0));
        // R5: exactly one pulse per served cluster, never two at once
        chk(onehot_err == 0 && dq.size() == nreq, "R5",
            $sformatf("%s release pulses act %0d exp %0d, multi-hot %0d exp 0",
            tag, dq.size(), nreq, onehot_err));
        // R4: stalls held the word
        chk(stall_err == 0, "R4", $sformatf("%s stall violations act %0d exp 0", tag, stall_err));
        if (nreq > 0) exp_ptr = (order[nreq-1] + 1) % N;
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(req == 1'b0 && rd == 1'b0 && done == '0, "R1",
            $sformatf("in reset req=%0b rd=%0b done=%h exp 0/0/0", req, rd, done));
        rst_n = 1'b1;
        @(negedge clk);
        chk(req == 1'b0 && rd == 1'b0 && done == '0, "R1",
            $sformatf("after reset req=%0b rd=%0b done=%h exp 0/0/0", req, rd, done));
        // R7: idle with nothing ready
        repeat (20) @(negedge clk);
        chk(idle_act == 0, "R7", $sformatf("activity while idle act %0d exp 0", idle_act));

        // R1/R2: all clusters at once, pointer starts at 0 and wraps
        ack_pct = 100;
        run_batch('1, 0, 2, "all16");
        // R8: header only
        run_batch(16'h0020, 0, 0, "hdr-only");
        // R2: sparse mask from pointer 6 -> 9, 12, then wrap to 3
        run_batch(16'h1208, 0, 3, "sparse");
        // R8: full buffer with heavy back-pressure
        ack_pct = 40;
        run_batch(16'h8000, 0, D - 1, "full-buf");
        // R4: rare acknowledge
        ack_pct = 8;
        run_batch(16'h0081, 0, 5, "slow-fifo");

        // Random batches
        for (int b = 0; b < 22; b++) begin
            logic [N-1:0] m;
            m = N'($urandom);
            if (m == '0) m[b % N] = 1'b1;
            ack_pct = 20 + int'($urandom % 81);
            run_batch(m, 24, -1, $sformatf("rand%0d", b));
        end

        // R6: reads only of ready clusters, across the whole run
        chk(unready_err == 0, "R6", $sformatf("reads of non-ready cluster act %0d exp 0", unready_err));
        idle_act = 0;
        repeat (20) @(negedge clk);
        chk(idle_act == 0, "R7", $sformatf("activity after drain act %0d exp 0", idle_act));

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: run did not finish, act hung exp done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule